// File: doc/BRIEF.md
# Card Slot Power Mode Controller

This block decides which supply rails reach a removable card slot. Three rail switches can be closed: an auxiliary rail, a 3.3 V main rail and a 1.5 V low rail. The block also decides when the output discharge pulldowns pull the slot rails to ground. Its inputs are flags that have already been qualified: auxiliary supply present, main input good, low input good, an active-low shutdown request, an active-low standby request and two active-low card-detect lines. It drives one enable per rail switch, a discharge enable, and a 3-bit mode code that can be observed.

Whether a card gets power depends on the order of events. A card that is already powered keeps its auxiliary rail when standby is asserted or when a primary input drops. A card that is detected while standby is low, or while a primary input is missing, gets no rail until the conditions are met. A shutdown request parks the slot with the pulldowns on. Releasing it returns the slot to the mode it held before. Changes in the switch enables pass through a break-before-make sequencer, so a rail switch and a pulldown are never on together, and each change between them is separated by idle cycles.

The mode code is registered one clock after the inputs are sampled. The enables follow the mode on the next clock, or later when a break-before-make gap has to pass first.

Top module: `slot_power_ctrl`

## Requirements
- R1: A card counts as present when at least one of the two detect lines is low. It counts as absent only when both lines are high. Each line alone is enough to power a card.
- R2: While the auxiliary flag is low, the mode becomes 0 (OFF) and every rail enable and the discharge enable go low. This takes priority over the shutdown request and every other input.
- R3: With auxiliary present and shutdown low, the mode becomes 1 (SHUTDOWN). All rail enables go low and discharge goes high. Releasing shutdown puts back the mode held just before shutdown was asserted.
- R4: With all three supplies good and no card present, the mode becomes 2 (NO CARD). All rails are off and discharge is on.
- R5: With all supplies good, standby high and a card present, the mode becomes 4 (CARD INSERTED). The auxiliary, main and low enables are all high and discharge is low.
- R6: From CARD INSERTED, standby going low or the main or low input dropping gives mode 3 (STANDBY). Only the auxiliary enable stays high. Recovery with standby high goes back to mode 4.
- R7: A card that is detected while standby is low, or while the main or low input is missing, gets mode 0 with no rail and no discharge. When the missing conditions are met later, the mode becomes 4.
- R8: A rail enable and the discharge enable are never high in the same cycle. Between the last rail enable falling and discharge rising, and between discharge falling and any rail enable rising, there are at least GAP_CYC cycles with all of them low.
- R9: Removing the card while in STANDBY or CARD INSERTED gives mode 2 on the next clock.
- R10: Synchronous reset gives mode 0 with all rail enables and the discharge enable low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aux_ok | input | 1 | Auxiliary supply present |
| main_ok | input | 1 | 3.3 V input good |
| low_ok | input | 1 | 1.5 V input good |
| shut_n | input | 1 | Shutdown request, active low |
| stby_n | input | 1 | Standby request, active low |
| det_a_n | input | 1 | Card detect line A, active low |
| det_b_n | input | 1 | Card detect line B, active low |
| en_aux | output | 1 | Auxiliary rail switch enable |
| en_main | output | 1 | 3.3 V rail switch enable |
| en_low | output | 1 | 1.5 V rail switch enable |
| dis_en | output | 1 | Output discharge pulldown enable |
| mode | output | 3 | Mode code: 0 OFF, 1 SHUTDOWN, 2 NO CARD, 3 STANDBY, 4 CARD INSERTED |

## Verification
The mode-transition properties assume that every input flag is synchronous to the clock and stays stable from one edge to the next, so that a condition seen at one edge produces its mode at the following one. The bench changes inputs only on falling edges and holds them for several cycles. Each timed sequence therefore starts from a settled mode. The break-before-make properties assume nothing about the inputs: they hold for any ordering of shutdown, detect and supply changes, and the bench crosses from a discharging mode into a powered one and back again to exercise both gap directions.

// File: rtl/slot_pwr_pkg.sv
package slot_pwr_pkg;
  localparam int N_RAILS = 3;
  localparam int MODE_W  = 3;

  typedef enum logic [MODE_W-1:0] {
    M_OFF    = 3'd0,
    M_SHUT   = 3'd1,
    M_NOCARD = 3'd2,
    M_STBY   = 3'd3,
    M_FULL   = 3'd4
  } pmode_e;

  // rail order in vectors: bit0 aux, bit1 main, bit2 low
  function automatic logic [N_RAILS-1:0] rails_for(pmode_e m);
    case (m)
      M_FULL:  rails_for = 3'b111;
      M_STBY:  rails_for = 3'b001;
      default: rails_for = 3'b000;
    endcase
  endfunction

  function automatic logic drain_for(pmode_e m);
    drain_for = (m == M_SHUT) || (m == M_NOCARD);
  endfunction
endpackage

// File: rtl/slot_mode_fsm.sv
module slot_mode_fsm
  import slot_pwr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   aux_ok,
  input  logic   prim_ok,
  input  logic   shut_n,
  input  logic   stby_n,
  input  logic   card,
  output pmode_e mode_q
);
  pmode_e saved_q;
  pmode_e mode_d;
  logic   ready;

  assign ready = prim_ok && stby_n;

  always_comb begin
    mode_d = mode_q;
    if (!aux_ok) begin
      mode_d = M_OFF;
    end else if (!shut_n) begin
      mode_d = M_SHUT;
    end else begin
      case (mode_q)
        M_SHUT:   mode_d = saved_q;
        M_OFF, M_NOCARD: begin
          if (card)         mode_d = ready ? M_FULL : M_OFF;
          else              mode_d = prim_ok ? M_NOCARD : M_OFF;
        end
        M_FULL: begin
          if (!card)        mode_d = M_NOCARD;
          else if (!ready)  mode_d = M_STBY;
          else              mode_d = M_FULL;
        end
        M_STBY: begin
          if (!card)        mode_d = M_NOCARD;
          else if (ready)   mode_d = M_FULL;
          else              mode_d = M_STBY;
        end
        default:            mode_d = M_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= M_OFF;
      saved_q <= M_OFF;
    end else begin
      mode_q <= mode_d;
      if (mode_d == M_SHUT && mode_q != M_SHUT)
        saved_q <= mode_q;
    end
  end
endmodule

// File: rtl/slot_bbm_seq.sv
module slot_bbm_seq #(
  parameter int N_RAILS = 3,
  parameter int GAP_CYC = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_RAILS-1:0] want_sw,
  input  logic               want_dis,
  output logic [N_RAILS-1:0] sw_q,
  output logic               dis_q
);
  localparam int CNT_W = $clog2(GAP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(GAP_CYC);
  localparam logic [CNT_W-1:0] CNT_NEED = CNT_W'(GAP_CYC - 1);

  logic [CNT_W-1:0] quiet_cnt_q;
  logic             quiet;
  logic             gap_ok;
  logic             sw_allow;

  assign quiet    = (sw_q == '0) && !dis_q;
  assign gap_ok   = quiet && (quiet_cnt_q >= CNT_NEED);
  assign sw_allow = !dis_q && ((sw_q != '0) || gap_ok);

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q        <= '0;
      dis_q       <= 1'b0;
      quiet_cnt_q <= '0;
    end else begin
      sw_q  <= sw_allow ? want_sw : '0;
      dis_q <= want_dis && (dis_q || gap_ok);
      if (!quiet)
        quiet_cnt_q <= '0;
      else if (quiet_cnt_q != CNT_MAX)
        quiet_cnt_q <= quiet_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/slot_power_ctrl.sv
module slot_power_ctrl #(
  parameter int GAP_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       aux_ok,
  input  logic       main_ok,
  input  logic       low_ok,
  input  logic       shut_n,
  input  logic       stby_n,
  input  logic       det_a_n,
  input  logic       det_b_n,
  output logic       en_aux,
  output logic       en_main,
  output logic       en_low,
  output logic       dis_en,
  output logic [2:0] mode
);
  import slot_pwr_pkg::*;

  pmode_e             mode_q;
  logic [N_RAILS-1:0] sw;
  logic               card;

  assign card = !det_a_n || !det_b_n;

  slot_mode_fsm u_fsm (
    .clk     (clk),
    .rst     (rst),
    .aux_ok  (aux_ok),
    .prim_ok (main_ok && low_ok),
    .shut_n  (shut_n),
    .stby_n  (stby_n),
    .card    (card),
    .mode_q  (mode_q)
  );

  slot_bbm_seq #(.N_RAILS(N_RAILS), .GAP_CYC(GAP_CYC)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .want_sw  (rails_for(mode_q)),
    .want_dis (drain_for(mode_q)),
    .sw_q     (sw),
    .dis_q    (dis_en)
  );

  assign en_aux  = sw[0];
  assign en_main = sw[1];
  assign en_low  = sw[2];
  assign mode    = mode_q;
endmodule

// File: rtl/slot_power_ctrl_chk.sv
module slot_power_ctrl_chk #(
  parameter int GAP_CYC = 1
) (
  input logic       clk,
  input logic       rst,
  input logic       aux_ok,
  input logic       main_ok,
  input logic       low_ok,
  input logic       shut_n,
  input logic       stby_n,
  input logic       det_a_n,
  input logic       det_b_n,
  input logic       en_aux,
  input logic       en_main,
  input logic       en_low,
  input logic       dis_en,
  input logic [2:0] mode
);
  localparam int IW = $clog2(GAP_CYC + 1);
  localparam logic [IW-1:0] IMAX = IW'(GAP_CYC);

  logic          any_sw;
  logic          card;
  logic [IW-1:0] idle_q;

  assign any_sw = en_aux || en_main || en_low;
  assign card   = !det_a_n || !det_b_n;

  always_ff @(posedge clk) begin
    if (rst)
      idle_q <= IMAX;
    else if (any_sw || dis_en)
      idle_q <= '0;
    else if (idle_q != IMAX)
      idle_q <= idle_q + 1'b1;
  end

  a_r8_never_overlap: assert property (@(posedge clk) disable iff (rst)
    !(any_sw && dis_en));

  a_r8_gap_before_drain: assert property (@(posedge clk) disable iff (rst)
    $rose(dis_en) |-> idle_q >= IMAX);

  a_r8_gap_before_rail: assert property (@(posedge clk) disable iff (rst)
    (any_sw && !$past(any_sw)) |-> idle_q >= IMAX);

  a_r2_aux_loss_off: assert property (@(posedge clk) disable iff (rst)
    !aux_ok |=> mode == 3'd0);

  a_r3_shutdown_mode: assert property (@(posedge clk) disable iff (rst)
    (aux_ok && !shut_n) |=> mode == 3'd1);

  a_r6_standby_entry: assert property (@(posedge clk) disable iff (rst)
    (mode == 3'd4 && aux_ok && shut_n && card && !stby_n) |=> mode == 3'd3);

  a_r9_removal: assert property (@(posedge clk) disable iff (rst)
    ((mode == 3'd3 || mode == 3'd4) && aux_ok && shut_n && !card) |=> mode == 3'd2);
endmodule

bind slot_power_ctrl slot_power_ctrl_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst(rst), .aux_ok(aux_ok), .main_ok(main_ok), .low_ok(low_ok),
  .shut_n(shut_n), .stby_n(stby_n), .det_a_n(det_a_n), .det_b_n(det_b_n),
  .en_aux(en_aux), .en_main(en_main), .en_low(en_low), .dis_en(dis_en),
  .mode(mode)
);

// File: tb/slot_power_ctrl_tb_top.sv
module slot_power_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic aux_ok = 1'b1, main_ok = 1'b1, low_ok = 1'b1;
  logic shut_n = 1'b1, stby_n = 1'b1, det_a_n = 1'b1, det_b_n = 1'b1;
  logic en_aux, en_main, en_low, dis_en;
  logic [2:0] mode;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  slot_power_ctrl dut_i (
    .clk(clk), .rst(rst), .aux_ok(aux_ok), .main_ok(main_ok), .low_ok(low_ok),
    .shut_n(shut_n), .stby_n(stby_n), .det_a_n(det_a_n), .det_b_n(det_b_n),
    .en_aux(en_aux), .en_main(en_main), .en_low(en_low), .dis_en(dis_en),
    .mode(mode)
  );

  task automatic expect_out(string tag, logic [2:0] m, logic [2:0] rails, logic d);
    logic [2:0] got;
    got = {en_low, en_main, en_aux};
    total++;
    if (mode !== m || got !== rails || dis_en !== d) begin
      bad++;
      $display("FAIL %s: mode=%0d rails=%b dis=%b expected mode=%0d rails=%b dis=%b",
               tag, mode, got, dis_en, m, rails, d);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(3);
    expect_out("R10 reset state", 3'd0, 3'b000, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_no_card;
    cyc(6);
    expect_out("R4 no card", 3'd2, 3'b000, 1'b1);
  endtask

  task automatic t_insert_timed;
    det_b_n = 1'b0;  // R1: line B alone
    cyc(1);
    expect_out("R1 R5 mode first", 3'd4, 3'b000, 1'b1);
    cyc(1);
    expect_out("R8 idle before rails", 3'd4, 3'b000, 1'b0);
    cyc(1);
    expect_out("R5 rails on", 3'd4, 3'b111, 1'b0);
  endtask

  task automatic t_remove_timed;
    det_b_n = 1'b1;
    cyc(1);
    expect_out("R9 removal to no card", 3'd2, 3'b111, 1'b0);
    cyc(1);
    expect_out("R8 idle before drain", 3'd2, 3'b000, 1'b0);
    cyc(1);
    expect_out("R8 drain after gap", 3'd2, 3'b000, 1'b1);
  endtask

  task automatic t_line_a;
    det_a_n = 1'b0;
    cyc(6);
    expect_out("R1 line A powers card", 3'd4, 3'b111, 1'b0);
  endtask

  task automatic t_standby;
    stby_n = 1'b0; cyc(6);
    expect_out("R6 standby request", 3'd3, 3'b001, 1'b0);
    stby_n = 1'b1; cyc(6);
    expect_out("R6 standby release", 3'd4, 3'b111, 1'b0);
    main_ok = 1'b0; cyc(6);
    expect_out("R6 main input lost", 3'd3, 3'b001, 1'b0);
    main_ok = 1'b1; cyc(6);
    expect_out("R6 main input back", 3'd4, 3'b111, 1'b0);
    low_ok = 1'b0; cyc(6);
    expect_out("R6 low input lost", 3'd3, 3'b001, 1'b0);
  endtask

  task automatic t_shutdown;
    shut_n = 1'b0; cyc(6);
    expect_out("R3 shutdown", 3'd1, 3'b000, 1'b1);
    shut_n = 1'b1; cyc(6);
    expect_out("R3 restore standby", 3'd3, 3'b001, 1'b0);
    low_ok = 1'b1; cyc(6);
    expect_out("R6 recover full", 3'd4, 3'b111, 1'b0);
  endtask

  task automatic t_aux_loss;
    shut_n = 1'b0; aux_ok = 1'b0; cyc(6);
    expect_out("R2 aux lost overrides shutdown", 3'd0, 3'b000, 1'b0);
    aux_ok = 1'b1; shut_n = 1'b1; cyc(6);
    expect_out("R2 aux back", 3'd4, 3'b111, 1'b0);
  endtask

  task automatic t_late_insert;
    det_a_n = 1'b1; cyc(6);
    expect_out("R9 removal settles", 3'd2, 3'b000, 1'b1);
    main_ok = 1'b0; cyc(6);
    expect_out("R7 primary missing no card", 3'd0, 3'b000, 1'b0);
    det_a_n = 1'b0; cyc(6);
    expect_out("R7 insert without primary", 3'd0, 3'b000, 1'b0);
    main_ok = 1'b1; cyc(6);
    expect_out("R7 primary returns", 3'd4, 3'b111, 1'b0);
    det_a_n = 1'b1; cyc(6);
    stby_n = 1'b0; det_b_n = 1'b0; cyc(6);
    expect_out("R7 insert under standby", 3'd0, 3'b000, 1'b0);
    stby_n = 1'b1; cyc(6);
    expect_out("R7 standby released", 3'd4, 3'b111, 1'b0);
  endtask

  task automatic t_remove_from_standby;
    stby_n = 1'b0; cyc(6);
    expect_out("R6 standby again", 3'd3, 3'b001, 1'b0);
    det_b_n = 1'b1; cyc(1);
    expect_out("R9 removal from standby", 3'd2, 3'b001, 1'b0);
    cyc(5);
    expect_out("R9 settles to drain", 3'd2, 3'b000, 1'b1);
  endtask

  initial begin
    t_reset();
    t_no_card();
    t_insert_timed();
    t_remove_timed();
    t_line_a();
    t_standby();
    t_shutdown();
    t_aux_loss();
    t_late_insert();
    t_remove_from_standby();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule